// File: doc/BRIEF.md
# Toggle-Request Word RAM Port

This block is a single-port, word-wide memory wrapper that sits between a state-machine datapath and a local storage array. The datapath never indexes the array. To request an access it drives a byte address, a write flag and (for a store) a 32-bit data word, and then inverts a request line. The wrapper is the only logic that reads or writes the array, and it does so from one process. This lets synthesis map the storage onto a RAM macro rather than onto flip-flops.

The wrapper runs on the falling edge of the shared clock. A request raised at a rising edge is carried out on the falling edge that follows. For a load, the returned word is ready by the next rising edge. The datapath therefore spends one wait state after each load before it uses the result. A store needs no wait, so back-to-back stores may be issued on consecutive rising edges.

Only aligned full-word accesses are served. A misaligned address, or a word index beyond the configured depth, is refused: the error output is raised and the storage is left untouched.

Top module: `tglreq_word_ram`

## Requirements
- R1: While reset is asserted and after its release, `rdata_o` reads 0 and `err_o` reads 0. The internal copy of the request line is cleared by reset, so the datapath must hold `req_tgl_i` low across reset.
- R2: An access is started only when `req_tgl_i` differs from the wrapper's stored copy of it, and each inversion causes exactly one access. Holding `req_tgl_i` at either level causes no access, whatever `addr_i`, `wr_i` and `wdata_i` do.
- R3: A request inverted at a rising edge is served at the next falling edge. Just after that rising edge, `rdata_o` still shows the previous value. At the following rising edge (the wait state), `rdata_o` shows the new word.
- R4: The word index is `addr_i` shifted right by two. A store (`wr_i`=1) writes all 32 bits of `wdata_i` to that word. Stores issued on consecutive rising edges are all performed.
- R5: A load (`wr_i`=0) returns the last word stored at that index. `rdata_o` then holds that value until the next accepted load, and stores do not change it.
- R6: A request with `addr_i[1:0]` not equal to 0 sets `err_o` to 1. It leaves memory unchanged and leaves `rdata_o` unchanged.
- R7: A request whose word index is at or above `DEPTH` sets `err_o` to 1 and is ignored. No word inside the range is written, so there is no wrap-around aliasing.
- R8: `err_o` is updated only when a request is served: it goes to 0 on an accepted request and holds its value between requests.
- R9: Reset does not clear the storage. Words written before a reset read back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the wrapper acts on its falling edge |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_tgl_i | input | 1 | Request line; each inversion asks for one access |
| wr_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | AW | Byte address; must be a multiple of four |
| wdata_i | input | 32 | Store data |
| rdata_o | output | 32 | Word returned by the last accepted load |
| err_o | output | 1 | Set when the last served request was refused |

## Verification
The bench fills the whole array with a burst of back-to-back stores. A detector that missed a toggle, or counted one twice, would leave a word stale. It then reads every word back, checking that the old value is still present before the falling edge. A wrapper acting on the rising edge would expose the new word one half-cycle early. Stores to every out-of-range word would overwrite low words if the index were truncated instead of range-checked. Misaligned stores and loads at every offset would corrupt a word, or replace the held read data, if alignment were ignored. Long stretches with a steady request line, and a reset in mid-run, show whether a design accesses memory on a level rather than on a change, or wipes the array on reset.

// File: rtl/tgr_pkg.sv
package tgr_pkg;

  // Outcome of one served request
  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_LOAD   = 2'd1,
    ACC_STORE  = 2'd2,
    ACC_REJECT = 2'd3
  } acc_kind_e;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BYTE_OFS = 2;  // log2 of bytes per word

endpackage

// File: rtl/tgr_rst_sync.sv
// Asynchronous assert, synchronous release, on the falling-edge domain.
module tgr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic srst_n_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = 1'b1;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(negedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sh_q <= '0;
    else           sh_q <= sh_d;
  end

  assign srst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/tgr_toggle_detect.sv
// Turns each inversion of the request line into a single-cycle request.
module tgr_toggle_detect (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic tgl_i,
  output logic req_o
);

  logic seen_q;
  logic seen_d;
  logic seen_en;

  assign req_o   = tgl_i ^ seen_q;
  assign seen_en = req_o;

  always_comb begin
    seen_d = seen_q;
    if (seen_en) seen_d = tgl_i;
  end

  always_ff @(negedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) seen_q <= 1'b0;
    else          seen_q <= seen_d;
  end

endmodule

// File: rtl/tgr_addr_check.sv
// Byte address to word index, alignment and range screening.
module tgr_addr_check
  import tgr_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  output logic [IDX_W-1:0] idx_o,
  output acc_kind_e        kind_o
);

  localparam int unsigned WW = AW - BYTE_OFS;

  logic [WW-1:0] word;
  logic          misaligned;
  logic          in_range;

  assign word       = addr_i[AW-1:BYTE_OFS];
  assign misaligned = |addr_i[BYTE_OFS-1:0];
  assign idx_o      = word[IDX_W-1:0];

  generate
    if (DEPTH == (1 << WW)) begin : g_full_map
      assign in_range = 1'b1;
    end else begin : g_part_map
      assign in_range = ({{(32-WW){1'b0}}, word} < 32'(DEPTH));
    end
  endgenerate

  always_comb begin
    kind_o = ACC_NONE;
    if (req_i) begin
      if (misaligned || !in_range) kind_o = ACC_REJECT;
      else if (wr_i)               kind_o = ACC_STORE;
      else                         kind_o = ACC_LOAD;
    end
  end

endmodule

// File: rtl/tgr_word_store.sv
// The only process that touches the array: written so a RAM is inferred.
module tgr_word_store #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(negedge clk_i) begin
    if (we_i) mem[idx_i] <= wdata_i;
    if (re_i) rd_q       <= mem[idx_i];
  end

  assign rdata_o = rd_q;

endmodule

// File: rtl/tglreq_word_ram.sv
module tglreq_word_ram
  import tgr_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              req_tgl_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              err_o
);

  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              srst_n;
  logic              req;
  logic [IDX_W-1:0]  idx;
  acc_kind_e         kind;
  logic [WORD_W-1:0] rd_raw;

  logic              err_q,   err_d;
  logic              valid_q, valid_d;

  tgr_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i    (clk_i),
    .arst_n_i (rst_n_i),
    .srst_n_o (srst_n)
  );

  tgr_toggle_detect i_detect (
    .clk_i   (clk_i),
    .rst_n_i (srst_n),
    .tgl_i   (req_tgl_i),
    .req_o   (req)
  );

  tgr_addr_check #(.AW(AW), .DEPTH(DEPTH), .IDX_W(IDX_W)) i_check (
    .req_i  (req),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .idx_o  (idx),
    .kind_o (kind)
  );

  tgr_word_store #(.DW(WORD_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) i_store (
    .clk_i   (clk_i),
    .we_i    (kind == ACC_STORE),
    .re_i    (kind == ACC_LOAD),
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .rdata_o (rd_raw)
  );

  // Next-state: error flag follows each served request; valid once a load lands
  always_comb begin
    err_d   = err_q;
    valid_d = valid_q;
    if (req)              err_d   = (kind == ACC_REJECT);
    if (kind == ACC_LOAD) valid_d = 1'b1;
  end

  always_ff @(negedge clk_i or negedge srst_n) begin
    if (!srst_n) begin
      err_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      err_q   <= err_d;
      valid_q <= valid_d;
    end
  end

  assign rdata_o = valid_q ? rd_raw : '0;
  assign err_o   = err_q;

endmodule

// File: rtl/tglreq_word_ram_chk.sv
module tglreq_word_ram_chk #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input logic          clk_i,
  input logic          srst_n,
  input logic          req_tgl_i,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [31:0]   rdata_o,
  input logic          err_o
);

  logic          prev_tgl_q;
  logic          seen;
  logic          mis;
  logic          fits;
  logic [AW-3:0] w;

  always_ff @(negedge clk_i or negedge srst_n) begin
    if (!srst_n) prev_tgl_q <= 1'b0;
    else         prev_tgl_q <= req_tgl_i;
  end

  assign seen = req_tgl_i != prev_tgl_q;
  assign mis  = addr_i[1:0] != 2'b00;
  assign w    = addr_i[AW-1:2];
  assign fits = 32'(w) < 32'(DEPTH);

  AST_MISALIGN_FLAGGED: assert property (@(negedge clk_i) disable iff (!srst_n)
    seen && mis |=> err_o); // R6

  AST_RANGE_FLAGGED: assert property (@(negedge clk_i) disable iff (!srst_n)
    seen && !mis && !fits |=> err_o); // R7

  AST_GOOD_CLEARS_ERR: assert property (@(negedge clk_i) disable iff (!srst_n)
    seen && !mis && fits |=> !err_o); // R8

  AST_ERR_HELD: assert property (@(negedge clk_i) disable iff (!srst_n)
    !seen |=> $stable(err_o)); // R8

  AST_RDATA_HELD: assert property (@(negedge clk_i) disable iff (!srst_n)
    !(seen && !wr_i && !mis && fits) |=> $stable(rdata_o)); // R5

endmodule

bind tglreq_word_ram tglreq_word_ram_chk #(.AW(AW), .DEPTH(DEPTH)) i_chk (
  .clk_i     (clk_i),
  .srst_n    (srst_n),
  .req_tgl_i (req_tgl_i),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .err_o     (err_o)
);

// File: tb/test_tglreq_word_ram.sv
`timescale 1ns/1ps
module test_tglreq_word_ram;

  localparam int AW    = 8;
  localparam int DEPTH = 16;
  localparam int WORDS = 1 << (AW - 2);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tgl;
  logic        wr;
  logic [AW-1:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        err;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] exp_mem [DEPTH];
  logic [31:0] exp_rd;

  always #2.5 clk = ~clk;

  tglreq_word_ram #(.AW(AW), .DEPTH(DEPTH)) i_tglreq_word_ram (
    .clk_i     (clk),
    .rst_n_i   (rst_n),
    .req_tgl_i (tgl),
    .wr_i      (wr),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .err_o     (err)
  );

  function automatic logic [31:0] pat(int i);
    return (32'h9E3779B9 * 32'(i + 1)) ^ 32'h0F0F0000;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Datapath state: drive a request at a rising edge and invert the line
  task automatic issue(input logic w, input int a, input logic [31:0] d);
    @(posedge clk);
    wr    = w;
    addr  = AW'(a);
    wdata = d;
    tgl   = ~tgl;
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  // Load: issue, check old data before the falling edge, wait state, sample
  task automatic load_chk(input string tag, input int a, input logic [31:0] exp, input logic exp_err);
    issue(1'b0, a, 32'h0);
    #1;
    chk({tag, " R3 pre-edge"}, rdata, exp_rd);
    settle();
    if (!exp_err) exp_rd = exp;
    chk(tag, rdata, exp_rd);
    chk({tag, " err R8"}, {31'b0, err}, {31'b0, exp_err});
  endtask

  task automatic readback_all(input string tag);
    for (int i = 0; i < DEPTH; i++) load_chk(tag, 4 * i, exp_mem[i], 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; tgl = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    exp_rd = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rdata in reset", rdata, 32'h0);
    chk("R1 err in reset", {31'b0, err}, 32'h0);
    @(posedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 rdata after release", rdata, 32'h0);
    chk("R1 err after release", {31'b0, err}, 32'h0);

    // R4/R2: back-to-back stores, one per rising edge
    for (int i = 0; i < DEPTH; i++) begin
      issue(1'b1, 4 * i, pat(i));
      exp_mem[i] = pat(i);
    end
    settle();
    chk("R5 store leaves rdata", rdata, 32'h0);
    readback_all("R4 burst readback");

    // R7: every out-of-range word
    for (int i = DEPTH; i < WORDS; i++) begin
      issue(1'b1, 4 * i, ~pat(i));
      settle();
      chk("R7 range err", {31'b0, err}, 32'h1);
    end
    load_chk("R7 range load", 4 * (DEPTH + 1), 32'h0, 1'b1);
    readback_all("R7 no alias");

    // R6: every misaligned offset, stores and loads
    for (int i = 0; i < DEPTH; i++) begin
      for (int k = 1; k < 4; k++) begin
        issue(1'b1, 4 * i + k, 32'hFFFF_FFFF);
        settle();
        chk("R6 misaligned store err", {31'b0, err}, 32'h1);
        load_chk("R6 misaligned load", 4 * i + k, 32'h0, 1'b1);
      end
    end

    // R2/R8: steady request line, inputs wander, nothing happens
    for (int c = 0; c < 8; c++) begin
      @(posedge clk);
      wr = 1'b1; addr = AW'(12 + 4 * (c % 2)); wdata = 32'hDEAD_0000 | 32'(c);
      #1;
      chk("R2 no access rdata", rdata, exp_rd);
      chk("R8 err held", {31'b0, err}, 32'h1);
    end
    tgl = ~tgl; wr = 1'b1; addr = 8'd12; wdata = 32'h1234_5678;
    exp_mem[3] = 32'h1234_5678;
    settle();
    chk("R8 err cleared", {31'b0, err}, 32'h0);
    for (int c = 0; c < 4; c++) begin
      @(posedge clk);
      wr = 1'b1; addr = 8'd16; wdata = 32'hBAD0_BAD0;
    end
    readback_all("R6 R2 readback");

    // R5: a store after a load does not disturb held data
    load_chk("R5 load", 4 * 5, exp_mem[5], 1'b0);
    issue(1'b1, 4 * 6, 32'hCAFE_F00D);
    exp_mem[6] = 32'hCAFE_F00D;
    settle();
    settle();
    chk("R5 rdata held over store", rdata, exp_mem[5]);
    load_chk("R5 new word", 4 * 6, 32'hCAFE_F00D, 1'b0);

    // R9: reset mid-run keeps storage
    @(posedge clk);
    tgl = 1'b0; rst_n = 1'b0;
    #1;
    chk("R1 rdata cleared by reset", rdata, 32'h0);
    exp_rd = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 err after mid reset", {31'b0, err}, 32'h0);
    readback_all("R9 after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule